// File: doc/BRIEF.md
# Programmable Coincidence and Veto Unit

This block is the trigger decision stage of a multi-counter telescope. It receives eight active-high detector hit lines, already synchronous to the system clock. A two-bit role field per line makes that line a coincidence member, a veto source, or leaves it out. Each coincidence hit is stretched into a short window, and a coincidence is declared on the cycle where the windows of all member lines first overlap. Any veto-source hit opens a longer veto window.

The coincidence result passes through a fixed delay line. The delay places it near the middle of a veto window that opened in the same cycle as the coincidence inputs. Two fixed-width output pulses are produced. One output fires on every accepted coincidence. The other fires only when no veto window is open at the moment the delayed result arrives. Both outputs are long enough to drive a counter or a slower logic stage downstream.

A coincidence that arrives while an output pulse is still running is dropped. A saturating per-output counter records each dropped event.

Top module: `coinc_veto_unit`

## Requirements
- R1: Line i takes its role from `sel_i[2i+1:2i]`, where 2'b01 means coincidence, 2'b10 means veto, and 2'b00 or 2'b11 means off.
- R2: A hit on a coincidence line keeps that line's window open for COINC_WIN cycles, and a new hit reloads the window. A coincidence is declared on the cycle where the windows of all coincidence lines first overlap. With COINC_WIN=4, hits on two lines 3 cycles apart coincide, and hits 4 cycles apart do not.
- R3: A hit on any veto line opens a shared veto window of VETO_WIN cycles. Hits on several veto lines combine as an OR.
- R4: Take the clock edge that samples the hit completing a coincidence as edge 0. `coinc_o` goes high after edge COINC_DLY+1.
- R5: `coinc_o` fires for every accepted coincidence, whether or not a veto window is open.
- R6: `coinc_nv_o` fires together with `coinc_o` only if the veto window is closed when the delayed coincidence is sampled. With the defaults, a veto hit up to 5 cycles after the coincidence edge blocks it, and one 6 cycles after does not. A veto hit 2 cycles before the coincidence edge blocks it, and one 3 cycles before does not.
- R7: Hits on lines set to off change neither output.
- R8: `cfg_valid_o` is high exactly when at least one line has the coincidence role. While it is low, neither output can rise.
- R9: Each output pulse stays high for exactly OUT_WIDTH cycles.
- R10: A trigger that reaches an output while that output is still high is dropped. The output's lost counter (`lost_coinc_o` or `lost_nv_o`) then increases by one and saturates at its maximum. A trigger that arrives in the first cycle after the pulse ends starts a new pulse.
- R11: Reset clears all windows, the delay line, both outputs and both lost counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2*N_IN | Two-bit role field for each line |
| pulse_i | input | N_IN | Synchronous detector hits |
| coinc_o | output | 1 | Coincidence pulse, veto ignored |
| coinc_nv_o | output | 1 | Coincidence pulse, veto honoured |
| cfg_valid_o | output | 1 | At least one coincidence line selected |
| lost_coinc_o | output | CNT_W | Dropped triggers on coinc_o |
| lost_nv_o | output | CNT_W | Dropped triggers on coinc_nv_o |

## Verification
The bench probes the exact overlap edge of the coincidence window. A stretcher one cycle too long or too short would accept a 4-cycle separation or reject a 3-cycle one. It sweeps veto hits just before and just after the coincidence on both sides of the window. An off-by-one between the veto window and the delay line would block events it should pass, or pass events it should block. It drives off-role lines and a configuration with no coincidence lines; a decoder that treated 2'b11 as active, or an empty AND that read as true, would fire spuriously. It sends a second coincidence in the last cycle of an output pulse and again in the first cycle after it, to find a dead-time boundary that is one cycle off.

// File: rtl/cv_pkg.sv
package cv_pkg;
  typedef enum logic [1:0] {
    ROLE_OFF   = 2'b00,
    ROLE_COINC = 2'b01,
    ROLE_VETO  = 2'b10,
    ROLE_OFF_B = 2'b11
  } role_e;
endpackage

// File: rtl/cv_stretch.sv
module cv_stretch #(
  parameter int WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic open_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (trig_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);
endmodule

// File: rtl/cv_delay.sv
module cv_delay #(
  parameter int DEPTH = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] pipe_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[DEPTH-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/cv_pulse_gen.sv
module cv_pulse_gen #(
  parameter int WIDTH = 40,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] lost_o
);
  localparam int WW = $clog2(WIDTH + 1);
  localparam logic [WW-1:0] LOAD = WW'(WIDTH);

  logic [WW-1:0]    w_q;
  logic [CNT_W-1:0] lost_q;
  logic             busy;

  assign busy = (w_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            w_q <= '0;
    else if (trig_i && !busy) w_q <= LOAD;
    else if (busy)          w_q <= w_q - 1'b1;
  end

  // dead-time drop, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                lost_q <= '0;
    else if (trig_i && busy && (lost_q != '1)) lost_q <= lost_q + 1'b1;
  end

  assign pulse_o = busy;
  assign lost_o  = lost_q;
endmodule

// File: rtl/coinc_veto_unit.sv
module coinc_veto_unit
  import cv_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter int COINC_WIN = 4,
  parameter int VETO_WIN  = 8,
  parameter int COINC_DLY = 5,
  parameter int OUT_WIDTH = 40,
  parameter int CNT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*N_IN-1:0] sel_i,
  input  logic [N_IN-1:0]   pulse_i,
  output logic              coinc_o,
  output logic              coinc_nv_o,
  output logic              cfg_valid_o,
  output logic [CNT_W-1:0]  lost_coinc_o,
  output logic [CNT_W-1:0]  lost_nv_o
);
  logic [N_IN-1:0] is_coinc, is_veto, win_open;
  logic veto_hit, veto_open, and_hit, and_hit_q, coinc_evt, dly_evt;
  logic trig_raw, trig_clean;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_line
      role_e role;
      assign role        = role_e'(sel_i[2*i +: 2]);
      assign is_coinc[i] = (role == ROLE_COINC);
      assign is_veto[i]  = (role == ROLE_VETO);

      cv_stretch #(.WIN(COINC_WIN)) u_win (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (pulse_i[i] & is_coinc[i]),
        .open_o (win_open[i])
      );
    end
  endgenerate

  assign veto_hit = |(pulse_i & is_veto);

  cv_stretch #(.WIN(VETO_WIN)) u_veto (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (veto_hit),
    .open_o (veto_open)
  );

  assign cfg_valid_o = |is_coinc;
  // unselected lines count as satisfied; empty selection blocked by cfg_valid
  assign and_hit     = cfg_valid_o & (&(win_open | ~is_coinc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) and_hit_q <= 1'b0;
    else         and_hit_q <= and_hit;
  end

  assign coinc_evt = and_hit & ~and_hit_q;

  cv_delay #(.DEPTH(COINC_DLY)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (coinc_evt),
    .q_o    (dly_evt)
  );

  assign trig_raw   = dly_evt & cfg_valid_o;
  assign trig_clean = trig_raw & ~veto_open;

  cv_pulse_gen #(.WIDTH(OUT_WIDTH), .CNT_W(CNT_W)) u_out_raw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_raw),
    .pulse_o (coinc_o),
    .lost_o  (lost_coinc_o)
  );

  cv_pulse_gen #(.WIDTH(OUT_WIDTH), .CNT_W(CNT_W)) u_out_nv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_clean),
    .pulse_o (coinc_nv_o),
    .lost_o  (lost_nv_o)
  );
endmodule

// File: rtl/cv_checker.sv
module cv_checker #(
  parameter int OUT_WIDTH = 40,
  parameter int CNT_W     = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             coinc_o,
  input logic             coinc_nv_o,
  input logic             cfg_valid_o,
  input logic             veto_open,
  input logic [CNT_W-1:0] lost_coinc_o,
  input logic [CNT_W-1:0] lost_nv_o
);
  localparam int HW = $clog2(OUT_WIDTH + 2);

  logic [HW-1:0] hi_raw, hi_nv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_raw <= '0;
      hi_nv  <= '0;
    end else begin
      hi_raw <= coinc_o    ? hi_raw + 1'b1 : '0;
      hi_nv  <= coinc_nv_o ? hi_nv  + 1'b1 : '0;
    end
  end

  AST_RAW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(coinc_o) |-> (hi_raw == HW'(OUT_WIDTH))); // R9
  AST_NV_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(coinc_nv_o) |-> (hi_nv == HW'(OUT_WIDTH))); // R9
  AST_NO_CFG_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coinc_o) |-> $past(cfg_valid_o)); // R8
  AST_VETO_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coinc_nv_o) |-> !$past(veto_open)); // R6
  AST_LOST_RAW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lost_coinc_o >= $past(lost_coinc_o)) && (lost_coinc_o <= $past(lost_coinc_o) + 1)); // R10
  AST_LOST_NV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lost_nv_o >= $past(lost_nv_o)) && (lost_nv_o <= $past(lost_nv_o) + 1)); // R10
endmodule

bind coinc_veto_unit cv_checker #(.OUT_WIDTH(OUT_WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .coinc_o      (coinc_o),
  .coinc_nv_o   (coinc_nv_o),
  .cfg_valid_o  (cfg_valid_o),
  .veto_open    (veto_open),
  .lost_coinc_o (lost_coinc_o),
  .lost_nv_o    (lost_nv_o)
);

// File: tb/coinc_veto_unit_tb_top.sv
module coinc_veto_unit_tb_top;
  localparam int N_IN = 8, CW = 4, VW = 8, DLY = 5, OW = 40, CNT_W = 16;
  localparam int LAT = DLY + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2*N_IN-1:0] sel = '0;
  logic [N_IN-1:0] pulse = '0;
  logic coinc_o, coinc_nv_o, cfg_valid_o;
  logic [CNT_W-1:0] lost_coinc_o, lost_nv_o;

  int checks = 0, fails = 0;
  int rise_r, rise_c, first_r, first_c, hi_r;

  always #5 clk = ~clk;

  coinc_veto_unit #(.N_IN(N_IN), .COINC_WIN(CW), .VETO_WIN(VW), .COINC_DLY(DLY),
                    .OUT_WIDTH(OW), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .pulse_i(pulse),
    .coinc_o(coinc_o), .coinc_nv_o(coinc_nv_o), .cfg_valid_o(cfg_valid_o),
    .lost_coinc_o(lost_coinc_o), .lost_nv_o(lost_nv_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // role codes: 01 coincidence, 10 veto, 00/11 off
  function automatic logic [15:0] role(input int line, input logic [1:0] code);
    logic [15:0] r = '0;
    r[2*line +: 2] = code;
    return r;
  endfunction

  task automatic play(input logic [15:0] s, input logic [7:0] m0,
                      input logic [7:0] m1, input int t1, input int n);
    logic pr = 1'b0, pc = 1'b0;
    sel = s;
    pulse = '0;
    repeat (60) @(negedge clk);
    rise_r = 0; rise_c = 0; first_r = -1; first_c = -1; hi_r = 0;
    for (int i = 0; i < n; i++) begin
      pulse = ((i == 0) ? m0 : 8'h00) | ((i == t1) ? m1 : 8'h00);
      @(negedge clk);
      if (coinc_o && !pr) begin rise_r++; if (first_r < 0) first_r = i; end
      if (coinc_nv_o && !pc) begin rise_c++; if (first_c < 0) first_c = i; end
      if (coinc_o) hi_r++;
      pr = coinc_o; pc = coinc_nv_o;
    end
    pulse = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 coinc_o in reset", int'(coinc_o), 0);
    chk("R11 coinc_nv_o in reset", int'(coinc_nv_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 lost_coinc after reset", int'(lost_coinc_o), 0);
    chk("R11 lost_nv after reset", int'(lost_nv_o), 0);
    chk("R8 cfg_valid all off", int'(cfg_valid_o), 0);
  endtask

  task automatic t_single;
    play(role(0, 2'b01), 8'h01, 8'h00, -1, 60);
    chk("R8 cfg_valid one coinc line", int'(cfg_valid_o), 1);
    chk("R5 single-fold raw count", rise_r, 1);
    chk("R6 single-fold clean count", rise_c, 1);
    chk("R4 latency", first_r, LAT);
    chk("R9 pulse width", hi_r, OW);
  endtask

  task automatic t_fourfold;
    logic [15:0] s = role(0, 2'b01) | role(2, 2'b01) | role(4, 2'b01) | role(6, 2'b01);
    play(s, 8'h55, 8'h00, -1, 60);
    chk("R1 R2 fourfold all present", rise_r, 1);
    play(s, 8'h15, 8'h00, -1, 60);
    chk("R2 fourfold one missing", rise_r, 0);
  endtask

  task automatic t_overlap;
    logic [15:0] s = role(0, 2'b01) | role(1, 2'b01);
    play(s, 8'h01, 8'h02, 3, 60);
    chk("R2 separation 3 coincides", rise_r, 1);
    chk("R4 latency from last hit", first_r, 3 + LAT);
    play(s, 8'h01, 8'h02, 4, 60);
    chk("R2 separation 4 no coincidence", rise_r, 0);
  endtask

  task automatic t_veto;
    logic [15:0] s = role(0, 2'b01) | role(7, 2'b10) | role(3, 2'b10);
    play(s, 8'h81, 8'h00, -1, 60);
    chk("R5 raw fires under veto", rise_r, 1);
    chk("R6 simultaneous veto blocks", rise_c, 0);
    play(s, 8'h01, 8'h08, 5, 60);
    chk("R3 second veto line, late 5 blocks", rise_c, 0);
    play(s, 8'h01, 8'h80, 6, 60);
    chk("R6 veto 6 after passes", rise_c, 1);
    chk("R6 clean aligned with raw", first_c, first_r);
    play(s, 8'h80, 8'h01, 2, 60);
    chk("R6 veto 2 before blocks", rise_c, 0);
    play(s, 8'h80, 8'h01, 3, 60);
    chk("R6 veto 3 before passes", rise_c, 1);
  endtask

  task automatic t_off;
    logic [15:0] s = role(0, 2'b01) | role(1, 2'b11) | role(2, 2'b00) | role(5, 2'b11);
    play(s, 8'hFE, 8'h00, -1, 60);
    chk("R7 off lines do not trigger", rise_r, 0);
    play(s, 8'hFF, 8'h00, -1, 60);
    chk("R7 off lines do not veto", rise_c, 1);
  endtask

  task automatic t_nocfg;
    play(role(0, 2'b10) | role(1, 2'b11), 8'hFF, 8'hFF, 5, 60);
    chk("R8 cfg_valid low", int'(cfg_valid_o), 0);
    chk("R8 no raw output", rise_r, 0);
    chk("R8 no clean output", rise_c, 0);
  endtask

  task automatic t_dead;
    int lr, ln;
    lr = int'(lost_coinc_o); ln = int'(lost_nv_o);
    play(role(0, 2'b01), 8'h01, 8'h01, 10, 60);
    chk("R10 second event dropped", rise_r, 1);
    chk("R10 lost_coinc +1", int'(lost_coinc_o) - lr, 1);
    chk("R10 lost_nv +1", int'(lost_nv_o) - ln, 1);
    lr = int'(lost_coinc_o);
    play(role(0, 2'b01), 8'h01, 8'h01, 40, 100);
    chk("R10 last busy cycle drops", rise_r, 1);
    chk("R10 lost_coinc +1 at edge", int'(lost_coinc_o) - lr, 1);
    lr = int'(lost_coinc_o);
    play(role(0, 2'b01), 8'h01, 8'h01, 41, 100);
    chk("R10 first free cycle accepted", rise_r, 2);
    chk("R10 no loss when free", int'(lost_coinc_o) - lr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_fourfold();
    t_overlap();
    t_veto();
    t_off();
    t_nocfg();
    t_dead();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule